// File: doc/BRIEF.md
# Multi-Mode Sixteen-Bit Lookup Cell

This block models a four-input lookup cell whose sixteen one-bit storage locations can serve as one of three structures. A parameter fixed at build time picks the structure: a read-only function table, a single-port distributed RAM with one write port, or a sixteen-stage shift register whose taps can be selected. A second parameter holds the sixteen configuration bits that each location takes at start-up.

The address input always picks one location for the combinational data output. In RAM mode a clock edge with the enable high stores the data input at the addressed location. In shift mode the same edge pushes the data input into location 0 and moves every other location up by one. The address then works as a variable delay tap, and location 15 always drives the tail output. The active-low reset stands in for reconfiguration and reloads the configuration bits.

Top module: `lut_cell`

## Requirements
- R1: While reset is low, and after it is released, location i holds bit i of the configuration parameter CFG_BITS, for every i from 0 to 15, in every mode.
- R2: With MODE = 0 (lookup), `rd_bit` equals CFG_BITS[`sel`] for every value of `sel`.
- R3: With MODE = 0, `wr_en` and `bit_in` have no effect: no clock edge changes any location.
- R4: With MODE = 1 (RAM), a rising clock edge with `wr_en` high stores `bit_in` at location `sel`, and every other location keeps its value.
- R5: With MODE = 1, reads are combinational. A newly written value shows on `rd_bit` after the writing edge with no further clock, and `rd_bit` follows changes of `sel` without a clock.
- R6: With MODE = 1, a clock edge with `wr_en` low changes no location.
- R7: With MODE = 2 (shift), a rising edge with `wr_en` high moves `bit_in` into location 0 and the old location i into location i+1, for i from 0 to 14.
- R8: With MODE = 2, `rd_bit` equals location `sel`, so it shows the data input from `sel`+1 enabled edges before.
- R9: `tail_bit` always equals location 15 in every mode.
- R10: With MODE = 2, a clock edge with `wr_en` low changes no location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and shifts happen on its rising edge |
| rst_n | input | 1 | Active-low reset; reloads the configuration bits |
| sel | input | 4 | Location address for the read, the write and the tap |
| wr_en | input | 1 | Enables a write (RAM) or a shift (shift mode) |
| bit_in | input | 1 | Data to write or to shift in |
| rd_bit | output | 1 | Addressed location, read combinationally |
| tail_bit | output | 1 | Location 15 |

## Verification
The bench drives a write enable that is high while lookup mode is active. A design that let the table be written would return changed bits on the following scan. It reads a location right after the edge that wrote it, which catches a read path that was made registered and shows old data for one cycle. It reads every tap after each shift, so a shift in the wrong direction or one that drops location 0 shows up at the first tap that differs. It also pulses the clock with the enable low in the RAM and shift modes, which exposes a design that updates its storage without the enable.

// File: rtl/lut_cell.sv
module lut_cell #(
  parameter int unsigned ADDR_W   = 4,
  parameter logic [1:0]  MODE     = 2'd1,
  parameter logic [(1<<ADDR_W)-1:0] CFG_BITS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sel,
  input  logic              wr_en,
  input  logic              bit_in,
  output logic              rd_bit,
  output logic              tail_bit
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [1:0] MODE_ROM = 2'd0;
  localparam logic [1:0] MODE_RAM = 2'd1;
  localparam logic [1:0] MODE_SRL = 2'd2;
  localparam bit WRITABLE = (MODE != MODE_ROM);

  logic [DEPTH-1:0] cells;
  logic [DEPTH-1:0] cells_nxt;

  generate
    if (MODE == MODE_RAM) begin : g_ram
      always_comb begin
        cells_nxt      = cells;
        cells_nxt[sel] = bit_in;
      end
    end else if (MODE == MODE_SRL) begin : g_srl
      assign cells_nxt = {cells[DEPTH-2:0], bit_in};
    end else begin : g_rom
      assign cells_nxt = cells;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cells <= CFG_BITS;
    else if (wr_en && WRITABLE)
      cells <= cells_nxt;
  end

  assign rd_bit   = cells[sel];
  assign tail_bit = cells[DEPTH-1];

  generate
    if (MODE == MODE_ROM) begin : g_chk_rom
      AST_ROM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(cells)); // R3
      AST_ROM_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cells == CFG_BITS); // R2
    end
    if (MODE == MODE_RAM) begin : g_chk_ram
      AST_RAM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cells[$past(sel)] == $past(bit_in)); // R4
      AST_RAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cells)); // R6
    end
    if (MODE == MODE_SRL) begin : g_chk_srl
      AST_SRL_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cells[0] == $past(bit_in)); // R7
      AST_SRL_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tail_bit == $past(cells[DEPTH-2])); // R9
      AST_SRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cells)); // R10
    end
  endgenerate
endmodule

// File: tb/lut_cell_test.sv
module lut_cell_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] ROM_CFG = 16'hA5C3;
  localparam logic [15:0] RAM_CFG = 16'h1E69;
  localparam logic [15:0] SRL_CFG = 16'h8001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] sel = '0;
  logic wr_en = 1'b0;
  logic bit_in = 1'b0;
  logic rom_rd, rom_tail, ram_rd, ram_tail, srl_rd, srl_tail;

  int checks = 0;
  int errors = 0;
  logic [15:0] ram_ref, srl_ref;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_cell #(.ADDR_W(4), .MODE(2'd0), .CFG_BITS(ROM_CFG)) uut_rom (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .bit_in(bit_in),
    .rd_bit(rom_rd), .tail_bit(rom_tail));
  lut_cell #(.ADDR_W(4), .MODE(2'd1), .CFG_BITS(RAM_CFG)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .bit_in(bit_in),
    .rd_bit(ram_rd), .tail_bit(ram_tail));
  lut_cell #(.ADDR_W(4), .MODE(2'd2), .CFG_BITS(SRL_CFG)) uut_srl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .bit_in(bit_in),
    .rd_bit(srl_rd), .tail_bit(srl_tail));

  task automatic check(string req, logic act, logic exp, int idx);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at location %0d: actual %b expected %b", req, idx, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (wr_en) begin
      ram_ref[sel] = bit_in;
      srl_ref = {srl_ref[14:0], bit_in};
    end
    #1;
  endtask

  task automatic scan(int mode, string req);
    for (int a = 0; a < 16; a++) begin
      sel = a[3:0];
      #1;
      case (mode)
        0: check(req, rom_rd, ROM_CFG[a], a);
        1: check(req, ram_rd, ram_ref[a], a);
        default: check(req, srl_rd, srl_ref[a], a);
      endcase
    end
    case (mode)
      0: check("R9", rom_tail, ROM_CFG[15], 15);
      1: check("R9", ram_tail, ram_ref[15], 15);
      default: check("R9", srl_tail, srl_ref[15], 15);
    endcase
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b1; bit_in = 1'b1;
    #(CLK_PERIOD*2);
    ram_ref = RAM_CFG; srl_ref = SRL_CFG;
    scan(0, "R1"); scan(1, "R1"); scan(2, "R1");
    @(negedge clk); wr_en = 1'b0; rst_n = 1'b1;
    tick();
    scan(0, "R1"); scan(1, "R1"); scan(2, "R1");
  endtask

  task automatic t_rom_ignore();
    scan(0, "R2");
    for (int k = 0; k < 20; k++) begin
      sel = k[3:0]; wr_en = 1'b1; bit_in = ~ROM_CFG[k % 16];
      tick();
    end
    wr_en = 1'b0;
    scan(0, "R3");
  endtask

  task automatic t_ram_write();
    for (int a = 0; a < 16; a++) begin
      sel = a[3:0]; wr_en = 1'b1; bit_in = a[0] ^ a[2];
      tick();
      wr_en = 1'b0;
      check("R5", ram_rd, ram_ref[a], a);
    end
    scan(1, "R4");
    for (int a = 15; a >= 0; a -= 3) begin
      sel = a[3:0]; wr_en = 1'b1; bit_in = ~ram_ref[a];
      tick();
      wr_en = 1'b0;
      check("R5", ram_rd, ram_ref[a], a);
      scan(1, "R4");
    end
    scan(1, "R5");
  endtask

  task automatic t_ram_hold();
    wr_en = 1'b0;
    for (int k = 0; k < 16; k++) begin
      sel = k[3:0]; bit_in = ~ram_ref[k];
      tick();
    end
    scan(1, "R6");
  endtask

  task automatic t_srl_shift();
    logic [15:0] pat;
    pat = 16'b0110_1011_0010_1110;
    for (int k = 0; k < 20; k++) begin
      wr_en = 1'b1; bit_in = pat[k % 16];
      tick();
      wr_en = 1'b0;
      check("R7", srl_tail, srl_ref[15], 15);
      scan(2, "R8");
    end
    scan(2, "R7");
  endtask

  task automatic t_srl_hold();
    wr_en = 1'b0;
    for (int k = 0; k < 10; k++) begin
      bit_in = k[0];
      tick();
    end
    scan(2, "R10");
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_rom_ignore();
    t_ram_write();
    t_ram_hold();
    t_srl_shift();
    t_srl_hold();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule